// File: doc/BRIEF.md
# Coulomb-counting capacity tracker

This block does the charge bookkeeping of a battery gas gauge. It takes signed current samples, each marked by a valid strobe. A positive value is charge and a negative value is discharge. Each sample is reduced to a charge quantum by a fixed right shift of its magnitude. The block keeps three counters from these quanta: the remaining capacity, the learned full-charge capacity, and a wear counter that counts discharge and wraps.

A periodic tick takes a self-discharge step off the remaining capacity. When the pack voltage first drops below an empty threshold, the remaining capacity is forced to a small reset value. If the battery was discharged all the way from full to this point with no charge in between, the amount of charge removed becomes the new full-charge capacity.

Two select pins pick one of four constant sets. Each set holds an initial capacity, an empty reset value and a self-discharge step. A sequential divider turns the remaining capacity into a percentage of the full-charge capacity. A sleep request is raised after a long run with no current, or at zero percent.

Top module: `cap_tracker`

## Requirements
- R1: During synchronous reset (`rst_n` low), the remaining capacity and the wear counter clear to 0. The full-charge capacity loads `BASE_CAP + k*CAP_STEP`, where k is the value of `set_sel`, so `set_sel` = 0 picks the first set.
- R2: A valid positive sample adds |sample| >> `CHG_SHIFT` to the remaining capacity, saturating at the full-charge capacity. A zero sample, or an invalid one, changes nothing.
- R3: A valid negative sample subtracts |sample| >> `CHG_SHIFT`, with a floor at 0. While the pack voltage is below the empty threshold, and it is not the first such cycle, the remaining capacity is held and discharge does not lower it.
- R4: A self-discharge tick subtracts `SD_BASE << k`, with a floor at 0. The tick is skipped when any of these holds: the remaining capacity equals the full-charge capacity, the voltage is below the threshold, or a nonzero sample arrives in the same cycle.
- R5: In the first cycle where `pack_v < empty_thr` after a cycle where it was not, the remaining capacity is loaded with `(BASE_CAP + k*CAP_STEP) >> EMPTY_SHIFT`, limited to the full-charge capacity. Voltage already below the threshold at reset does not count as such a first cycle.
- R6: At that empty event, the full-charge capacity is replaced by the total discharge counted since the remaining capacity last equalled it. This happens only when the total is nonzero and no charge sample came after that full point.
- R7: A charge sample arriving after the full point cancels learning. The next empty event then leaves the full-charge capacity unchanged.
- R8: Each discharge sample adds its quantum to the wear counter, whatever the remaining capacity is. If the sum reaches the full-charge capacity or more, the wear counter becomes 0.
- R9: `soc_pct` reports floor(remaining*100/full), never above 100. It follows a change within 2*(`CAP_W`+8) cycles.
- R10: `sleep_req` is high when `IDLE_CYCLES` consecutive cycles have passed with no nonzero valid sample, or when `soc_pct` is 0.
- R11: The remaining capacity never exceeds the full-charge capacity, and this still holds after a smaller capacity has been learned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_sel | input | 2 | Constant-set select |
| cur_valid | input | 1 | Current sample strobe |
| cur_sample | input | CUR_W | Signed current sample, positive is charge |
| pack_v | input | V_W | Pack voltage |
| empty_thr | input | V_W | Empty voltage threshold |
| sd_tick | input | 1 | Self-discharge period tick |
| rcap_o | output | CAP_W | Remaining capacity |
| fcc_o | output | CAP_W | Full-charge capacity |
| cdc_o | output | CAP_W | Wear (cumulative discharge) counter |
| soc_pct | output | 7 | Relative state of charge in percent |
| sleep_req | output | 1 | Sleep request |

## Verification
The bench builds the tracker with 12-bit capacities, a 10-bit current sample, a shift of 2 and a base capacity of 400 in steps of 100. This lets a full charge, a complete learning discharge and a wear-counter wrap each fit in a few dozen samples. The idle limit is set to 40 cycles, so both edges of the sleep timeout can be checked directly. The 19-step divider settles within a short idle window, so the percentage is compared after every burst of random traffic. Reset is applied with three different set selects to exercise the per-set initial capacity and self-discharge steps.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
   typedef enum logic [1:0] {
      FLOW_NONE = 2'd0,
      FLOW_CHG  = 2'd1,
      FLOW_DIS  = 2'd2
   } flow_e;

   localparam int PCT_W    = 7;
   localparam int PCT_FULL = 100;
   localparam int N_SETS   = 4;
endpackage

// File: rtl/cap_set_table.sv
`timescale 1ns/1ps
module cap_set_table #(
   parameter int CAP_W       = 16,
   parameter int BASE_CAP    = 2000,
   parameter int CAP_STEP    = 500,
   parameter int EMPTY_SHIFT = 5,
   parameter int SD_BASE     = 1
) (
   input  logic [1:0]       sel,
   output logic [CAP_W-1:0] set_cap,
   output logic [CAP_W-1:0] set_empty,
   output logic [CAP_W-1:0] set_sd
);
   import cap_pkg::*;

   logic [CAP_W-1:0] cap_arr   [N_SETS];
   logic [CAP_W-1:0] empty_arr [N_SETS];
   logic [CAP_W-1:0] sd_arr    [N_SETS];

   // Set k: capacity grows by CAP_STEP, self-discharge step doubles.
   for (genvar gi = 0; gi < N_SETS; gi++) begin : g_set
      localparam int CAPV = BASE_CAP + gi * CAP_STEP;
      assign cap_arr[gi]   = CAP_W'(CAPV);
      assign empty_arr[gi] = CAP_W'(CAPV >> EMPTY_SHIFT);
      assign sd_arr[gi]    = CAP_W'(SD_BASE << gi);
   end

   assign set_cap   = cap_arr[sel];
   assign set_empty = empty_arr[sel];
   assign set_sd    = sd_arr[sel];
endmodule

// File: rtl/cap_ledger.sv
`timescale 1ns/1ps
module cap_ledger #(
   parameter int CAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cap_pkg::flow_e   flow,
   input  logic [CAP_W-1:0] delta,
   input  logic             below,
   input  logic             sd_tick,
   input  logic [CAP_W-1:0] set_cap,
   input  logic [CAP_W-1:0] set_empty,
   input  logic [CAP_W-1:0] set_sd,
   output logic [CAP_W-1:0] rcap,
   output logic [CAP_W-1:0] fcc,
   output logic [CAP_W-1:0] cdc
);
   import cap_pkg::*;

   logic [CAP_W-1:0] acc, rcap_n, fcc_n, cdc_n, acc_n;
   logic             learn, learn_n, below_q;
   logic [CAP_W:0]   acc_sum, cdc_sum;
   logic             full;

   assign full = (rcap == fcc);

   always_comb begin
      rcap_n  = rcap;
      fcc_n   = fcc;
      cdc_n   = cdc;
      acc_n   = full ? '0 : acc;
      learn_n = full ? 1'b1 : learn;
      acc_sum = '0;
      cdc_sum = '0;
      unique case (flow)
         FLOW_CHG: begin
            learn_n = 1'b0;
            rcap_n  = (delta >= (fcc - rcap)) ? fcc : rcap + delta;
         end
         FLOW_DIS: begin
            if (!below)
               rcap_n = (delta >= rcap) ? '0 : rcap - delta;
            acc_sum = {1'b0, acc_n} + {1'b0, delta};
            acc_n   = acc_sum[CAP_W] ? '1 : acc_sum[CAP_W-1:0];
            cdc_sum = {1'b0, cdc} + {1'b0, delta};
            cdc_n   = (cdc_sum >= {1'b0, fcc}) ? '0 : cdc_sum[CAP_W-1:0];
         end
         default: begin
            if (sd_tick && !full && !below)
               rcap_n = (set_sd >= rcap) ? '0 : rcap - set_sd;
         end
      endcase
      // Empty event: learn if the run from full was uninterrupted.
      if (below && !below_q) begin
         if (learn_n && (acc_n != '0)) begin
            fcc_n   = acc_n;
            learn_n = 1'b0;
            acc_n   = '0;
         end
         rcap_n = (set_empty > fcc_n) ? fcc_n : set_empty;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcap    <= '0;
         fcc     <= set_cap;
         cdc     <= '0;
         acc     <= '0;
         learn   <= 1'b0;
         below_q <= 1'b1;
      end else begin
         rcap    <= rcap_n;
         fcc     <= fcc_n;
         cdc     <= cdc_n;
         acc     <= acc_n;
         learn   <= learn_n;
         below_q <= below;
      end
   end
endmodule

// File: rtl/cap_soc_div.sv
`timescale 1ns/1ps
module cap_soc_div #(
   parameter int CAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAP_W-1:0] rcap,
   input  logic [CAP_W-1:0] fcc,
   output logic [6:0]       pct
);
   import cap_pkg::*;

   localparam int NUM_W = CAP_W + PCT_W;
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] q, q_n;
   logic [CAP_W-1:0] rem, rem_n, den;
   logic [CNT_W-1:0] cnt;
   logic [CAP_W:0]   trial;
   logic             ge;

   // One restoring step per cycle.
   always_comb begin
      trial = {rem, q[NUM_W-1]};
      ge    = (trial >= {1'b0, den});
      rem_n = ge ? CAP_W'(trial - {1'b0, den}) : trial[CAP_W-1:0];
      q_n   = {q[NUM_W-2:0], ge};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q   <= '0;
         rem <= '0;
         den <= '1;
         cnt <= '0;
         pct <= '0;
      end else if (cnt == '0) begin
         q   <= NUM_W'(rcap) * NUM_W'(PCT_FULL);
         den <= fcc;
         rem <= '0;
         cnt <= CNT_W'(NUM_W);
      end else begin
         q   <= q_n;
         rem <= rem_n;
         cnt <= cnt - 1'b1;
         if (cnt == CNT_W'(1))
            pct <= (q_n > NUM_W'(PCT_FULL)) ? 7'(PCT_FULL) : q_n[6:0];
      end
   end
endmodule

// File: rtl/cap_idle_timer.sv
`timescale 1ns/1ps
module cap_idle_timer #(
   parameter int IDLE_CYCLES = 3000000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  cap_pkg::flow_e flow,
   input  logic [6:0]     pct,
   output logic           sleep_req
);
   import cap_pkg::*;

   localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (flow != FLOW_NONE) cnt <= '0;
      else if (cnt != LIMIT)      cnt <= cnt + 1'b1;
   end

   assign sleep_req = (cnt == LIMIT) || (pct == '0);
endmodule

// File: rtl/cap_tracker.sv
`timescale 1ns/1ps
module cap_tracker #(
   parameter int CAP_W       = 16,
   parameter int CUR_W       = 12,
   parameter int V_W         = 12,
   parameter int CHG_SHIFT   = 2,
   parameter int BASE_CAP    = 2000,
   parameter int CAP_STEP    = 500,
   parameter int EMPTY_SHIFT = 5,
   parameter int SD_BASE     = 1,
   parameter int IDLE_CYCLES = 3000000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              set_sel,
   input  logic                    cur_valid,
   input  logic signed [CUR_W-1:0] cur_sample,
   input  logic [V_W-1:0]          pack_v,
   input  logic [V_W-1:0]          empty_thr,
   input  logic                    sd_tick,
   output logic [CAP_W-1:0]        rcap_o,
   output logic [CAP_W-1:0]        fcc_o,
   output logic [CAP_W-1:0]        cdc_o,
   output logic [6:0]              soc_pct,
   output logic                    sleep_req
);
   import cap_pkg::*;

   if (CAP_W < 8 || CAP_W > 24) begin : g_bad_cap_w
      $error("CAP_W out of range");
   end
   if (CUR_W > CAP_W || CHG_SHIFT >= CUR_W) begin : g_bad_cur_w
      $error("CUR_W or CHG_SHIFT inconsistent with CAP_W");
   end
   if (BASE_CAP < 1 || (BASE_CAP + 3 * CAP_STEP) >= (1 << CAP_W)) begin : g_bad_cap
      $error("capacity set does not fit CAP_W");
   end
   if ((SD_BASE << 3) >= (1 << CAP_W) || IDLE_CYCLES < 1) begin : g_bad_misc
      $error("self-discharge step or idle limit invalid");
   end

   logic [CUR_W-1:0] raw, mag;
   logic [CAP_W-1:0] delta, set_cap, set_empty, set_sd;
   flow_e            flow;
   logic             below;

   assign raw   = cur_sample;
   assign mag   = raw[CUR_W-1] ? (~raw + 1'b1) : raw;
   assign delta = CAP_W'(mag >> CHG_SHIFT);
   assign below = (pack_v < empty_thr);

   always_comb begin
      if (!cur_valid || raw == '0) flow = FLOW_NONE;
      else if (raw[CUR_W-1])       flow = FLOW_DIS;
      else                         flow = FLOW_CHG;
   end

   cap_set_table #(
      .CAP_W(CAP_W), .BASE_CAP(BASE_CAP), .CAP_STEP(CAP_STEP),
      .EMPTY_SHIFT(EMPTY_SHIFT), .SD_BASE(SD_BASE)
   ) u_sets (
      .sel(set_sel), .set_cap(set_cap), .set_empty(set_empty), .set_sd(set_sd)
   );

   cap_ledger #(.CAP_W(CAP_W)) u_ledger (
      .clk(clk), .rst_n(rst_n), .flow(flow), .delta(delta), .below(below),
      .sd_tick(sd_tick), .set_cap(set_cap), .set_empty(set_empty),
      .set_sd(set_sd), .rcap(rcap_o), .fcc(fcc_o), .cdc(cdc_o)
   );

   cap_soc_div #(.CAP_W(CAP_W)) u_div (
      .clk(clk), .rst_n(rst_n), .rcap(rcap_o), .fcc(fcc_o), .pct(soc_pct)
   );

   cap_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
      .clk(clk), .rst_n(rst_n), .flow(flow), .pct(soc_pct), .sleep_req(sleep_req)
   );
endmodule

// File: rtl/cap_tracker_chk.sv
`timescale 1ns/1ps
module cap_tracker_chk #(
   parameter int CAP_W = 16,
   parameter int CUR_W = 12,
   parameter int V_W   = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cur_valid,
   input logic signed [CUR_W-1:0] cur_sample,
   input logic [V_W-1:0]          pack_v,
   input logic [V_W-1:0]          empty_thr,
   input logic [CAP_W-1:0]        rcap_o,
   input logic [CAP_W-1:0]        fcc_o,
   input logic [CAP_W-1:0]        cdc_o,
   input logic [6:0]              soc_pct
);
   logic low_v, is_dis, is_chg;
   assign low_v  = (pack_v < empty_thr);
   assign is_dis = cur_valid && cur_sample[CUR_W-1];
   assign is_chg = cur_valid && !cur_sample[CUR_W-1] && (cur_sample != '0);

   assert_rcap_le_fcc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rcap_o <= fcc_o);

   assert_charge_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_chg && !low_v) |=> (rcap_o >= $past(rcap_o)));

   assert_dis_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dis && !low_v) |=> (rcap_o <= $past(rcap_o)));

   assert_hold_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dis && low_v && $past(low_v)) |=> $stable(rcap_o));

   assert_cdc_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_dis |=> ((cdc_o < fcc_o) || !$stable(fcc_o)));

   assert_fcc_only_at_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fcc_o) |-> $past(low_v));

   assert_pct_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soc_pct <= 7'd100);
endmodule

bind cap_tracker cap_tracker_chk #(.CAP_W(CAP_W), .CUR_W(CUR_W), .V_W(V_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid), .cur_sample(cur_sample),
   .pack_v(pack_v), .empty_thr(empty_thr), .rcap_o(rcap_o), .fcc_o(fcc_o),
   .cdc_o(cdc_o), .soc_pct(soc_pct)
);

// File: tb/tb_cap_tracker.sv
`timescale 1ns/1ps
module tb_cap_tracker;
   localparam int CAP_W = 12, CUR_W = 10, V_W = 10, SHIFT = 2;
   localparam int BASE = 400, STEP = 100, ESH = 4, SDB = 1, IDLE = 40;
   localparam int THR = 100, VHI = 200, VLO = 50;

   logic clk = 0, rst_n = 0, cur_valid = 0, sd_tick = 0;
   logic [1:0] set_sel = 0;
   logic signed [CUR_W-1:0] cur_sample = '0;
   logic [V_W-1:0] pack_v = V_W'(VHI), empty_thr = V_W'(THR);
   logic [CAP_W-1:0] rcap_o, fcc_o, cdc_o;
   logic [6:0] soc_pct;
   logic sleep_req;

   int checks = 0, fails = 0, sel_i = 0;
   int m_rcap, m_fcc, m_cdc, m_acc, m_learn, m_below, m_idle;
   bit done = 0;

   always #5 clk = ~clk;

   cap_tracker #(.CAP_W(CAP_W), .CUR_W(CUR_W), .V_W(V_W), .CHG_SHIFT(SHIFT),
      .BASE_CAP(BASE), .CAP_STEP(STEP), .EMPTY_SHIFT(ESH), .SD_BASE(SDB),
      .IDLE_CYCLES(IDLE)) dut (
      .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .cur_valid(cur_valid),
      .cur_sample(cur_sample), .pack_v(pack_v), .empty_thr(empty_thr),
      .sd_tick(sd_tick), .rcap_o(rcap_o), .fcc_o(fcc_o), .cdc_o(cdc_o),
      .soc_pct(soc_pct), .sleep_req(sleep_req));

   function automatic int cap_of(int k);   return BASE + k * STEP; endfunction
   function automatic int empty_of(int k); return cap_of(k) >> ESH; endfunction
   function automatic int sd_of(int k);    return SDB << k;         endfunction
   function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(int k);
      @(negedge clk);
      rst_n = 0; set_sel = 2'(k); sel_i = k;
      cur_valid = 0; sd_tick = 0; pack_v = V_W'(VHI);
      repeat (3) @(negedge clk);
      rst_n = 1;
      m_rcap = 0; m_fcc = cap_of(k); m_cdc = 0; m_acc = 0;
      m_learn = 0; m_below = 1; m_idle = 0;
      chk("R1 rcap", int'(rcap_o), 0);
      chk("R1 fcc", int'(fcc_o), cap_of(k));
      chk("R1 cdc", int'(cdc_o), 0);
   endtask

   // Reference model, written from the requirements.
   task automatic model(bit v, int c, bit sd, int pv);
      int d, acc_n, learn_n, rcap_n, fcc_n, cdc_n;
      bit full, below;
      d = ((c < 0) ? -c : c) >> SHIFT;
      full = (m_rcap == m_fcc);
      below = (pv < THR);
      acc_n = full ? 0 : m_acc;
      learn_n = full ? 1 : m_learn;
      rcap_n = m_rcap; fcc_n = m_fcc; cdc_n = m_cdc;
      if (v && c > 0) begin
         learn_n = 0;
         rcap_n = imin(m_rcap + d, m_fcc);
      end else if (v && c < 0) begin
         if (!below) rcap_n = (d >= m_rcap) ? 0 : m_rcap - d;
         acc_n = imin(acc_n + d, (1 << CAP_W) - 1);
         cdc_n = (m_cdc + d >= m_fcc) ? 0 : m_cdc + d;
      end else if (sd && !full && !below) begin
         rcap_n = (sd_of(sel_i) >= m_rcap) ? 0 : m_rcap - sd_of(sel_i);
      end
      if (below && !m_below) begin
         if (learn_n != 0 && acc_n != 0) begin
            fcc_n = acc_n; learn_n = 0; acc_n = 0;
         end
         rcap_n = imin(empty_of(sel_i), fcc_n);
      end
      m_rcap = rcap_n; m_fcc = fcc_n; m_cdc = cdc_n; m_acc = acc_n;
      m_learn = learn_n; m_below = below;
      if (v && c != 0) m_idle = 0;
      else if (m_idle < IDLE) m_idle++;
   endtask

   task automatic step(string tag, bit v, int c, bit sd, int pv);
      @(negedge clk);
      cur_valid = v; cur_sample = CUR_W'(c); sd_tick = sd; pack_v = V_W'(pv);
      @(posedge clk);
      model(v, c, sd, pv);
      #1;
      chk(tag, int'(rcap_o), m_rcap);
      chk("R6 fcc", int'(fcc_o), m_fcc);
      chk("R8 cdc", int'(cdc_o), m_cdc);
   endtask

   task automatic settle();
      int ep;
      for (int i = 0; i < 50; i++) step("R11 idle", 0, 0, 0, VHI);
      ep = (m_rcap * 100) / m_fcc;
      chk("R9 pct", int'(soc_pct), ep);
      chk("R10 sleep", int'(sleep_req), ((m_idle >= IDLE) || ep == 0) ? 1 : 0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      do_reset(0);
      settle();                                   // R10: 0 percent sleeps
      chk("R10 sleep at zero", int'(sleep_req), 1);
      for (int i = 0; i < 41; i++) step("R2 charge", 1, 40, 0, VHI);
      chk("R2 saturate", int'(rcap_o), 400);
      step("R2 zero sample", 1, 0, 0, VHI);
      step("R2 sub-quantum", 1, 3, 0, VHI);
      step("R4 tick at full", 0, 0, 1, VHI);
      chk("R4 full no tick", int'(rcap_o), 400);
      step("R3 discharge", 1, -400, 0, VHI);
      step("R4 tick", 0, 0, 1, VHI);
      chk("R4 step", int'(rcap_o), 299);
      step("R4 tick with sample", 1, -4, 1, VHI);
      chk("R4 sample wins", int'(rcap_o), 298);
      for (int i = 0; i < IDLE - 1; i++) step("R10 idle", 0, 0, 0, VHI);
      chk("R9 pct 74", int'(soc_pct), 74);
      chk("R10 before limit", int'(sleep_req), 0);
      step("R10 idle", 0, 0, 0, VHI);
      chk("R10 at limit", int'(sleep_req), 1);
      step("R3 discharge", 1, -400, 0, VHI);
      step("R3 discharge", 1, -400, 0, VHI);
      step("R5 empty", 0, 0, 0, VLO);
      chk("R6 learned", int'(fcc_o), 301);
      chk("R5 empty value", int'(rcap_o), 25);
      chk("R8 cdc total", int'(cdc_o), 301);
      step("R3 hold", 1, -40, 0, VLO);
      chk("R3 held", int'(rcap_o), 25);
      chk("R8 wrap", int'(cdc_o), 0);
      for (int i = 0; i < 4; i++) step("R11 charge", 1, 400, 0, VHI);
      chk("R11 new limit", int'(rcap_o), 301);
      step("R7 discharge", 1, -400, 0, VHI);
      step("R7 charge", 1, 40, 0, VHI);
      for (int i = 0; i < 3; i++) step("R7 discharge", 1, -400, 0, VHI);
      step("R7 empty", 0, 0, 0, VLO);
      chk("R7 no learn", int'(fcc_o), 301);
      settle();
      do_reset(2);
      step("R2 charge", 1, 400, 0, VHI);
      step("R4 set step", 0, 0, 1, VHI);
      chk("R4 step set2", int'(rcap_o), 96);
      do_reset(1);
      for (int blk = 0; blk < 12; blk++) begin
         for (int i = 0; i < 250; i++) begin
            int c, pv;
            bit v, sd;
            v = ($urandom_range(0, 9) < 8);
            c = (blk % 2 == 0) ? int'($urandom_range(0, 260)) - 60
                               : int'($urandom_range(0, 260)) - 200;
            sd = ($urandom_range(0, 9) == 0);
            pv = ($urandom_range(0, 24) == 0) ? VLO : VHI;
            step("R11 random", v, c, sd, pv);
         end
         settle();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule